// File: doc/BRIEF.md
# Oversampled SPI Sample-Readback Slave

This block is an SPI slave that lives entirely in a fast system clock domain. The serial clock, the serial data input and the active-low select line are each brought in through a two-flop synchronizer. The block then finds serial clock edges by comparing the newest synchronized value with the one before it. Nothing in the block is clocked by the serial clock. Every receive and transmit step is a system-clock cycle that carries a detected edge. Because of this, a slow serial bit rate, such as a few hundred kHz against a clock of tens of MHz, never makes the shifter move faster than the link.

A small bank of capture registers is filled from a parallel ADC port. Each register holds one 14-bit sample and is written on a valid strobe. A master selects the slave and clocks in a 16-bit command: an address byte, then a data byte that the block does not use. When the command completes, the addressed sample is copied into a parallel-in serial-out shifter. The block returns it over the next 16 serial clocks as a 16-bit word, most significant bit first, with the sample zero-extended. The bus uses SPI mode 0.

Top module: `spi_capture_slave`

## Requirements
- R1: While `rst` is high, `miso` is driven 0 in the cycle after each clock edge.
- R2: While the synchronized select line is inactive (`cs_n` high), `miso` is 0 and the receive state is held cleared.
- R3: A command is the first 16 bits sampled on rising `sclk` edges after select, MSB first. Bits 15..8 are the address. Bits 7..0 are a data byte that has no effect on the reply. The readback value is loaded exactly once, on the 16th rising edge.
- R4: `miso` changes only on a detected falling `sclk` edge, or when the select line goes inactive. The first reply bit appears on the falling edge that ends the 16th command bit, so the master samples reply bit k on rising edge 17+(15-k).
- R5: The reply is the 14-bit capture register zero-extended to 16 bits, so reply bits 15 and 14 are 0. It is sent MSB first.
- R6: A `smp_valid` pulse writes `smp_data` into capture register `smp_sel`. A later read of that address returns the new value.
- R7: An address of `NUM_REGS` or above returns 0x0000.
- R8: The reply uses a snapshot taken at command completion. A capture write into the addressed register during the reply does not change the bits that follow.
- R9: Raising `cs_n` in the middle of a frame discards the partial command. The next selection decodes its command from its own first bit.
- R10: Each serial clock transition produces at most one detected edge. A rising edge and a falling edge are never detected in the same cycle.
- R11: After the 16 reply bits, further serial clocks while selected shift out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Capture strobe for the parallel sample port |
| smp_sel | input | 2 | Capture register index written by the strobe |
| smp_data | input | 14 | Parallel ADC sample |
| sclk | input | 1 | Serial clock from the master, asynchronous |
| mosi | input | 1 | Serial data from the master, asynchronous |
| cs_n | input | 1 | Active-low select from the master, asynchronous |
| miso | output | 1 | Serial data to the master |

## Verification
The checks assume that each serial clock level lasts longer than the three-cycle path through the synchronizer and the edge detector. They also assume that `cs_n` and `mosi` change only while `sclk` is low. Only under these conditions is "one detected edge per transition" and "MISO moves only on falling edges" a property of the block rather than of the wiring. The bench holds each serial clock level for eight system clocks. It changes `mosi` and `cs_n` only in the low phase, and it samples `miso` just before it raises `sclk`, where a mode-0 master would sample it.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    localparam int unsigned CMD_BITS  = 16;
    localparam int unsigned ADDR_BITS = 8;
    localparam int unsigned CNT_W     = $clog2(CMD_BITS + 1);

    // One cycle's view of the synchronized serial pins.
    typedef struct packed {
        logic active;   // select asserted
        logic rise;     // rising serial clock edge seen this cycle
        logic fall;     // falling serial clock edge seen this cycle
        logic din;      // synchronized serial data input
    } spi_evt_t;

    typedef enum logic {
        PH_CMD   = 1'b0,
        PH_REPLY = 1'b1
    } rx_phase_t;

    // Zero-extend a capture sample into the reply word.
    function automatic logic [15:0] widen16(input logic [15:0] v);
        return v;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_rd_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk,
    input  logic     mosi,
    input  logic     cs_n,
    output spi_evt_t evt
);
    localparam int unsigned      LINES   = 3;
    localparam logic [LINES-1:0] RST_VAL = 3'b100; // select idle high

    logic [LINES-1:0] pin_in;
    logic [LINES-1:0] chain [STAGES];
    logic [LINES-1:0] synced;
    logic             sclk_prev;

    assign pin_in = {cs_n, mosi, sclk};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= RST_VAL;
            sclk_prev <= 1'b0;
        end else begin
            chain[0] <= pin_in;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
            sclk_prev <= chain[STAGES-1][0];
        end
    end

    assign synced     = chain[STAGES-1];
    assign evt.active = ~synced[2];
    assign evt.rise   = evt.active &  synced[0] & ~sclk_prev;
    assign evt.fall   = evt.active & ~synced[0] &  sclk_prev;
    assign evt.din    = synced[1];

endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
    import spi_rd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  spi_evt_t             evt,
    output logic                 cmd_done,
    output logic [ADDR_BITS-1:0] cmd_addr
);
    logic [CMD_BITS-1:0] sr;
    logic [CNT_W-1:0]    cnt;
    rx_phase_t           phase;
    logic                last_bit;

    assign last_bit = evt.rise && (phase == PH_CMD) && (cnt == CNT_W'(CMD_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst || !evt.active) begin
            sr       <= '0;
            cnt      <= '0;
            phase    <= PH_CMD;
            cmd_done <= 1'b0;
        end else begin
            cmd_done <= last_bit;
            if (evt.rise && phase == PH_CMD) begin
                sr  <= {sr[CMD_BITS-2:0], evt.din};
                cnt <= cnt + 1'b1;
                if (last_bit) phase <= PH_REPLY;
            end
        end
    end

    assign cmd_addr = sr[CMD_BITS-1 -: ADDR_BITS];

endmodule

// File: rtl/sample_bank.sv
module sample_bank
    import spi_rd_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 14,
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned WORD_W   = 16,
    localparam int unsigned SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [SAMPLE_W-1:0]  wr_data,
    input  logic [ADDR_BITS-1:0] rd_addr,
    output logic [WORD_W-1:0]    rd_word
);
    logic [SAMPLE_W-1:0] bank [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                  bank[g] <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))    bank[g] <= wr_data;
        end
    end

    // Addresses outside the bank match no entry and read as zero.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_BITS'(i)) rd_word = WORD_W'(bank[i]);
        end
    end

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter
    import spi_rd_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  spi_evt_t          evt,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    output logic              miso
);
    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst || !evt.active) begin
            sr   <= '0;
            miso <= 1'b0;
        end else if (load) begin
            sr <= load_word;
        end else if (evt.fall) begin
            miso <= sr[WORD_W-1];
            sr   <= {sr[WORD_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/spi_capture_slave.sv
module spi_capture_slave
    import spi_rd_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = 14,
    parameter int unsigned NUM_REGS    = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned WORD_W     = CMD_BITS,
    localparam int unsigned SEL_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SEL_W-1:0]    smp_sel,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                sclk,
    input  logic                mosi,
    input  logic                cs_n,
    output logic                miso
);
    spi_evt_t             evt;
    logic                 cmd_done;
    logic [ADDR_BITS-1:0] cmd_addr;
    logic [WORD_W-1:0]    rd_word;
    logic                 cs_act;
    logic                 sclk_rise;
    logic                 sclk_fall;

    assign cs_act    = evt.active;
    assign sclk_rise = evt.rise;
    assign sclk_fall = evt.fall;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .mosi (mosi),
        .cs_n (cs_n),
        .evt  (evt)
    );

    spi_cmd_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .cmd_done (cmd_done),
        .cmd_addr (cmd_addr)
    );

    sample_bank #(
        .SAMPLE_W (SAMPLE_W),
        .NUM_REGS (NUM_REGS),
        .WORD_W   (WORD_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (smp_valid),
        .wr_sel  (smp_sel),
        .wr_data (smp_data),
        .rd_addr (cmd_addr),
        .rd_word (rd_word)
    );

    spi_tx_shifter #(.WORD_W(WORD_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .load      (cmd_done),
        .load_word (widen16(rd_word)),
        .miso      (miso)
    );

endmodule

// File: rtl/spi_capture_slave_chk.sv
module spi_capture_slave_chk (
    input logic clk,
    input logic rst,
    input logic miso,
    input logic cs_act,
    input logic sclk_rise,
    input logic sclk_fall,
    input logic cmd_done
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !miso); // R1

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !miso); // R2

    AST_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        cmd_done |-> $past(sclk_rise)); // R3

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd_done |=> !cmd_done); // R3

    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(miso) |-> $past(sclk_fall || !cs_act)); // R4

    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(sclk_rise && sclk_fall)); // R10

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> !sclk_rise); // R10

endmodule

bind spi_capture_slave spi_capture_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .miso      (miso),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cmd_done  (cmd_done)
);

// File: tb/spi_capture_slave_tb.sv
module spi_capture_slave_tb;

    localparam int HALF  = 8;   // system clocks per serial clock level
    localparam int NVEC  = 6;
    // {address, data byte, expected 16-bit reply}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h00, 8'h5A, 16'h1234},
        {8'h01, 8'hFF, 16'h3FFF},
        {8'h02, 8'h00, 16'h0001},
        {8'h03, 8'hC3, 16'h2AAA},
        {8'h04, 8'h11, 16'h0000},
        {8'hFF, 8'hA5, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [1:0]  smp_sel = '0;
    logic [13:0] smp_data = '0;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic        cs_n = 1'b1;
    logic        miso;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    spi_capture_slave u_dut (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_sel   (smp_sel),
        .smp_data  (smp_data),
        .sclk      (sclk),
        .mosi      (mosi),
        .cs_n      (cs_n),
        .miso      (miso)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic capture(input logic [1:0] sel, input logic [13:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_sel = sel; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // One mode-0 bit: drive while low, sample miso just before the rise.
    task automatic spi_bit(input logic b, output logic got);
        mosi = b;
        wait_clks(HALF);
        got  = miso;
        sclk = 1'b1;
        wait_clks(HALF);
        sclk = 1'b0;
    endtask

    // Full frame: 16 command bits, then nrep reply clocks. An optional
    // capture write to reg wsel happens in the low phase of reply bit 4.
    task automatic xfer(input logic [7:0] addr, input logic [7:0] dbyte, input int nrep,
                        input bit do_wr, input logic [1:0] wsel, input logic [13:0] wdat,
                        output logic [31:0] reply);
        logic [15:0] cmd;
        logic        got;
        cmd   = {addr, dbyte};
        reply = '0;
        @(negedge clk);
        cs_n = 1'b0;
        wait_clks(HALF);
        for (int i = 15; i >= 0; i--) spi_bit(cmd[i], got);
        for (int i = 0; i < nrep; i++) begin
            if (do_wr && i == 4) begin
                smp_valid = 1'b1; smp_sel = wsel; smp_data = wdat;
                @(negedge clk);
                smp_valid = 1'b0;
            end
            spi_bit(1'b0, got);
            reply = {reply[30:0], got};
        end
        wait_clks(HALF);
        cs_n = 1'b1;
        wait_clks(2 * HALF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R4 watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic        got;

        wait_clks(5);
        check("R1 miso during reset", {31'b0, miso}, 32'h0);
        rst = 1'b0;
        wait_clks(3);
        check("R2 miso idle after reset", {31'b0, miso}, 32'h0);

        // R6: fill the capture bank through the parallel port
        capture(2'd0, 14'h1234);
        capture(2'd1, 14'h3FFF);
        capture(2'd2, 14'h0001);
        capture(2'd3, 14'h2AAA);

        // R3 R5 R7: table of command frames
        for (int v = 0; v < NVEC; v++) begin
            xfer(VEC[v][31:24], VEC[v][23:16], 16, 1'b0, 2'd0, 14'h0, r);
            check($sformatf("R5/R7 vector %0d addr %h", v, VEC[v][31:24]),
                  r, {16'h0, VEC[v][15:0]});
        end

        // R2: miso low while deselected
        check("R2 miso with cs_n high", {31'b0, miso}, 32'h0);

        // R9: abort mid-command, then a full frame decodes from its own start
        @(negedge clk);
        cs_n = 1'b0;
        wait_clks(HALF);
        for (int i = 0; i < 5; i++) spi_bit(1'b1, got);
        cs_n = 1'b1;
        wait_clks(2 * HALF);
        check("R2 miso after abort", {31'b0, miso}, 32'h0);
        xfer(8'h02, 8'h77, 16, 1'b0, 2'd0, 14'h0, r);
        check("R9 frame after abort", r, 32'h0000_0001);

        // R8: capture write into the addressed register during the reply
        xfer(8'h00, 8'h00, 16, 1'b1, 2'd0, 14'h0F0F, r);
        check("R8 snapshot keeps old value", r, 32'h0000_1234);
        // R6: the new value is visible on the next read
        xfer(8'h00, 8'h00, 16, 1'b0, 2'd0, 14'h0, r);
        check("R6 updated capture read", r, 32'h0000_0F0F);

        // R11: extra clocks after the reply shift zeros
        xfer(8'h01, 8'h00, 20, 1'b0, 2'd0, 14'h0, r);
        check("R11 trailing bits zero", r, 32'h0003_FFF0);

        // R3 R10: data byte has no effect; same address, different data byte
        xfer(8'h03, 8'h00, 16, 1'b0, 2'd0, 14'h0, r);
        check("R3/R10 data byte ignored", r, 32'h0000_2AAA);

        // R1: reset during idle keeps miso low and clears the bank
        @(negedge clk); rst = 1'b1;
        wait_clks(3);
        check("R1 miso in second reset", {31'b0, miso}, 32'h0);
        rst = 1'b0;
        wait_clks(3);
        xfer(8'h01, 8'h00, 16, 1'b0, 2'd0, 14'h0, r);
        check("R1 bank cleared by reset", r, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule